// File: doc/BRIEF.md
# Band-Synchronised Table Lookup Search

This block searches a table held in a rotating band store. Software or a sequencer supplies a signed ten-digit decimal search argument and a starting band, then pulses start. The store, modelled outside the block, streams one word per clock together with that word's slot index within the band. The block tells the store which band to read. From the first slot-zero word after the start is accepted, it compares each word against the argument. It stops at the first word whose value is greater than or equal to the argument and reports that word's decimal address.

Each band has fifty slots. Only the first forty-eight take part in the search. The two trailing slots form a gap. During the gap the block advances its band select, so the next band's slot zero is compared on the very next revolution and no revolution is lost. If the last band runs out without a hit, the block finishes with a not-found indication. The result stays on the outputs until a new search is accepted.

Top module: `tlu_search`

## Requirements
- R1: After reset, done_o, not_found_o, match_addr_o and rd_band_o are all zero.
- R2: A start_i seen while idle is accepted. The argument and start_band_i are captured, and rd_band_o takes start_band_i. Comparison begins with the first word whose slot_i is 0 after the accepting edge. Words in earlier slots are ignored, even if they satisfy the compare.
- R3: The search stops at the first compared word that is greater than or equal to the argument, an equal value included. done_o rises on the edge after that word is presented.
- R4: Words are sign-magnitude. Bit 40 is the sign (1 = negative) and bits 39:0 are ten BCD digits, with the most significant digit in bits 39:36. Any negative value is below any positive value. Among negatives, the larger magnitude is the smaller value. +0 and -0 compare equal.
- R5: Words in slots 48 and 49 are never compared.
- R6: When slot 47 of the current band passes without a hit, rd_band_o increments on that edge. The next band's slot 0 is then compared in the following revolution.
- R7: On a hit, match_addr_o holds band × 50 + slot as four BCD digits, with the thousands digit in bits 15:12.
- R8: If slot 47 of band 19 (the last band) passes without a hit, done_o and not_found_o both rise together and match_addr_o is 0. On a hit, not_found_o stays 0.
- R9: A start_i seen while a search is running is ignored. The running search finishes with its own argument and band sequence.
- R10: done_o, not_found_o and match_addr_o hold until the next accepted start. That start clears done_o and not_found_o on its accepting edge.
- R11: When word_valid_i is low, the word presented in that cycle is not compared. The slot index still advances the band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a search (accepted only when idle) |
| start_band_i | input | 5 | First band to search |
| arg_i | input | 41 | Search argument, sign plus ten BCD digits |
| word_valid_i | input | 1 | Streamed word is usable this cycle |
| word_i | input | 41 | Streamed table word, sign plus ten BCD digits |
| slot_i | input | 6 | Slot index of the streamed word, 0 to 49 |
| rd_band_o | output | 5 | Band the store should stream |
| match_addr_o | output | 16 | Decimal address of the hit, four BCD digits |
| done_o | output | 1 | Search finished; held until next start |
| not_found_o | output | 1 | Search finished without a hit |

## Verification
Every result is registered once. done_o, not_found_o and match_addr_o therefore change on the edge that samples the deciding slot: the hit slot, or slot 47 of the last band. rd_band_o steps on the edge that samples slot 47. The bench drives every input at the falling edge and advances its store model by non-blocking update at the rising edge. At the first falling edge where done_o is seen, it checks that the store has moved exactly one slot past the deciding slot. This pins the latency to one cycle. A clear on start is checked at the falling edge right after the accepting edge.

// File: rtl/tlu_pkg.sv
`timescale 1ns/1ps
package tlu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_SCAN = 2'd2
  } tlu_state_e;
endpackage

// File: rtl/tlu_digit_cmp.sv
`timescale 1ns/1ps
// Digit-serial magnitude compare, most significant digit decides first.
module tlu_digit_cmp #(
  parameter int DIGITS = 10,
  localparam int MAG_W = 4 * DIGITS
) (
  input  logic [MAG_W-1:0] a_i,
  input  logic [MAG_W-1:0] b_i,
  output logic             gt_o,
  output logic             eq_o
);
  logic [DIGITS:0] gt_c;
  logic [DIGITS:0] eq_c;

  assign gt_c[DIGITS] = 1'b0;
  assign eq_c[DIGITS] = 1'b1;

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    logic [3:0] a_d, b_d;
    assign a_d     = a_i[4*k +: 4];
    assign b_d     = b_i[4*k +: 4];
    assign gt_c[k] = gt_c[k+1] | (eq_c[k+1] & (a_d > b_d));
    assign eq_c[k] = eq_c[k+1] & (a_d == b_d);
  end

  assign gt_o = gt_c[0];
  assign eq_o = eq_c[0];
endmodule

// File: rtl/tlu_ge_cmp.sv
`timescale 1ns/1ps
// Signed decimal word >= argument, sign-magnitude with +0 == -0.
module tlu_ge_cmp #(
  parameter int DIGITS = 10,
  localparam int MAG_W = 4 * DIGITS
) (
  input  logic             w_sign_i,
  input  logic [MAG_W-1:0] w_mag_i,
  input  logic             a_sign_i,
  input  logic [MAG_W-1:0] a_mag_i,
  output logic             ge_o
);
  logic mag_gt, mag_eq, w_zero, a_zero;

  tlu_digit_cmp #(.DIGITS(DIGITS)) u_mag (
    .a_i (w_mag_i),
    .b_i (a_mag_i),
    .gt_o(mag_gt),
    .eq_o(mag_eq)
  );

  assign w_zero = (w_mag_i == '0);
  assign a_zero = (a_mag_i == '0);

  always_comb begin
    if (w_zero && a_zero)             ge_o = 1'b1;
    else if (!w_sign_i && !a_sign_i)  ge_o = mag_gt | mag_eq;
    else if (!w_sign_i &&  a_sign_i)  ge_o = 1'b1;
    else if ( w_sign_i && !a_sign_i)  ge_o = 1'b0;
    else                              ge_o = ~mag_gt;
  end
endmodule

// File: rtl/tlu_addr_bcd.sv
`timescale 1ns/1ps
// band * SLOTS_PER_BAND + slot, converted to packed BCD by shift-add-3.
module tlu_addr_bcd #(
  parameter int BAND_W         = 5,
  parameter int SLOT_W         = 6,
  parameter int SLOTS_PER_BAND = 50,
  parameter int ADDR_DIGITS    = 4,
  localparam int ADDR_W        = 4 * ADDR_DIGITS
) (
  input  logic [BAND_W-1:0] band_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] bin;
  logic [ADDR_W-1:0] bcd;

  always_comb begin
    bin = ADDR_W'(band_i) * ADDR_W'(SLOTS_PER_BAND) + ADDR_W'(slot_i);
    bcd = '0;
    for (int i = ADDR_W - 1; i >= 0; i--) begin
      for (int d = 0; d < ADDR_DIGITS; d++) begin
        if (bcd[4*d +: 4] >= 4'd5) bcd[4*d +: 4] = bcd[4*d +: 4] + 4'd3;
      end
      bcd = {bcd[ADDR_W-2:0], bin[i]};
    end
    addr_o = bcd;
  end
endmodule

// File: rtl/tlu_search.sv
`timescale 1ns/1ps
module tlu_search
  import tlu_pkg::*;
#(
  parameter int DIGITS         = 10,
  parameter int SLOTS_PER_BAND = 50,
  parameter int SEARCH_SLOTS   = 48,
  parameter int NUM_BANDS      = 20,
  parameter int ADDR_DIGITS    = 4,
  localparam int MAG_W  = 4 * DIGITS,
  localparam int WORD_W = MAG_W + 1,
  localparam int SLOT_W = $clog2(SLOTS_PER_BAND),
  localparam int BAND_W = $clog2(NUM_BANDS),
  localparam int ADDR_W = 4 * ADDR_DIGITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BAND_W-1:0] start_band_i,
  input  logic [WORD_W-1:0] arg_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [BAND_W-1:0] rd_band_o,
  output logic [ADDR_W-1:0] match_addr_o,
  output logic              done_o,
  output logic              not_found_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SEARCH_SLOTS - 1);
  localparam logic [SLOT_W-1:0] WIN_END   = SLOT_W'(SEARCH_SLOTS);
  localparam logic [BAND_W-1:0] LAST_BAND = BAND_W'(NUM_BANDS - 1);

  tlu_state_e        state_q;
  logic [BAND_W-1:0] band_q;
  logic [WORD_W-1:0] arg_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q, nf_q;

  logic busy, at_first, scanning, cmp_en, ge, hit, win_end, last_band;
  logic [ADDR_W-1:0] hit_addr;

  assign busy      = (state_q != ST_IDLE);
  assign at_first  = (state_q == ST_ARM) && (slot_i == '0);
  assign scanning  = (state_q == ST_SCAN) || at_first;
  assign cmp_en    = scanning && (slot_i < WIN_END) && word_valid_i;
  assign hit       = cmp_en && ge;
  assign win_end   = scanning && (slot_i == LAST_SLOT);
  assign last_band = (band_q >= LAST_BAND);

  tlu_ge_cmp #(.DIGITS(DIGITS)) u_cmp (
    .w_sign_i(word_i[WORD_W-1]),
    .w_mag_i (word_i[MAG_W-1:0]),
    .a_sign_i(arg_q[WORD_W-1]),
    .a_mag_i (arg_q[MAG_W-1:0]),
    .ge_o    (ge)
  );

  tlu_addr_bcd #(
    .BAND_W        (BAND_W),
    .SLOT_W        (SLOT_W),
    .SLOTS_PER_BAND(SLOTS_PER_BAND),
    .ADDR_DIGITS   (ADDR_DIGITS)
  ) u_addr (
    .band_i(band_q),
    .slot_i(slot_i),
    .addr_o(hit_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      band_q  <= '0;
      arg_q   <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
      nf_q    <= 1'b0;
    end else if (!busy) begin
      if (start_i) begin
        state_q <= ST_ARM;
        band_q  <= start_band_i;
        arg_q   <= arg_i;
        addr_q  <= '0;
        done_q  <= 1'b0;
        nf_q    <= 1'b0;
      end
    end else if (hit) begin
      state_q <= ST_IDLE;
      addr_q  <= hit_addr;
      done_q  <= 1'b1;
    end else if (win_end) begin
      if (last_band) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
        nf_q    <= 1'b1;
      end else begin
        state_q <= ST_SCAN;
        band_q  <= band_q + 1'b1;
      end
    end else if (at_first) begin
      state_q <= ST_SCAN;
    end
  end

  assign rd_band_o    = band_q;
  assign match_addr_o = addr_q;
  assign done_o       = done_q;
  assign not_found_o  = nf_q;

  assert_hit_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && hit) |=> (done_o && !not_found_o));

  assert_equal_hits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en && word_i == arg_q) |-> ge);

  assert_neg_below_pos_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en && word_i[WORD_W-1] && !arg_q[WORD_W-1] && word_i[MAG_W-1:0] != '0) |-> !ge);

  assert_gap_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SCAN && slot_i >= WIN_END) |=> !done_o);

  assert_band_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && rd_band_o != $past(rd_band_o))
      |-> ($past(slot_i) == LAST_SLOT && rd_band_o == $past(rd_band_o) + 1'b1));

  assert_nf_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    not_found_o |-> done_o);

  assert_busy_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i && slot_i != LAST_SLOT) |=> (rd_band_o == $past(rd_band_o)));

  assert_start_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && start_i) |=> (!done_o && !not_found_o));

  assert_invalid_no_hit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !word_valid_i) |=> !(done_o && !not_found_o && !$past(done_o)));
endmodule

// File: tb/tlu_search_tb.sv
`timescale 1ns/1ps
module tlu_search_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [4:0]  start_band_i = '0;
  logic [40:0] arg_i = '0;
  logic        word_valid_i;
  logic [40:0] word_i;
  logic [5:0]  slot_i;
  logic [4:0]  rd_band_o;
  logic [15:0] match_addr_o;
  logic        done_o, not_found_o;

  int n_checks = 0;
  int n_fail   = 0;
  int slot_cnt = 0;
  bit mask_en  = 1'b0;
  int mask_band = 0;
  int mask_slot = 0;

  always #2 clk_i = ~clk_i;

  tlu_search u_dut (
    .clk_i, .rst_ni, .start_i, .start_band_i, .arg_i, .word_valid_i,
    .word_i, .slot_i, .rd_band_o, .match_addr_o, .done_o, .not_found_o
  );

  function automatic logic [40:0] enc(bit s, longint m);
    logic [40:0] w;
    longint t;
    t = m;
    w = '0;
    w[40] = s;
    for (int d = 0; d < 10; d++) begin
      w[4*d +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return w;
  endfunction

  // table entry value: 1000*(band*50+slot) - 500000, strictly rising
  function automatic logic [40:0] entry_word(int b, int s);
    longint v;
    v = 64'(1000) * longint'(b * 50 + s) - 64'(500000);
    return enc(v < 0, (v < 0) ? -v : v);
  endfunction

  function automatic int bcd2int(logic [15:0] a);
    return int'(a[15:12]) * 1000 + int'(a[11:8]) * 100 + int'(a[7:4]) * 10 + int'(a[3:0]);
  endfunction

  assign slot_i       = 6'(slot_cnt);
  assign word_i       = entry_word(int'(rd_band_o), slot_cnt);
  assign word_valid_i = !(mask_en && int'(rd_band_o) == mask_band && slot_cnt == mask_slot);

  // store model advances at the rising edge after the DUT samples
  initial forever begin
    @(posedge clk_i);
    slot_cnt <= (slot_cnt == 49) ? 0 : slot_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic start_pulse(input int band, input bit sgn, input longint mag, input int ph);
    while (slot_cnt != ph) @(negedge clk_i);
    start_i      = 1'b1;
    start_band_i = 5'(band);
    arg_i        = enc(sgn, mag);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_check(input bit exp_nf, input logic [15:0] exp_addr, input string tag);
    int cnt = 0;
    int n, exp_slot, exp_band;
    while (!done_o && cnt < 2500) begin
      @(negedge clk_i);
      cnt++;
    end
    n        = bcd2int(exp_addr);
    exp_slot = exp_nf ? 48 : ((n % 50) + 1) % 50;
    exp_band = exp_nf ? 19 : n / 50;
    check(done_o == 1'b1, {tag, " R3 done"}, done_o, 1);
    check(not_found_o == exp_nf, {tag, " R8 not_found"}, not_found_o, exp_nf);
    check(match_addr_o == exp_addr, {tag, " R7 addr"}, match_addr_o, exp_addr);
    check(slot_cnt == exp_slot, {tag, " R3 latency"}, slot_cnt, exp_slot);
    check(int'(rd_band_o) == exp_band, {tag, " R6 band"}, rd_band_o, exp_band);
  endtask

  localparam int NV = 11;
  localparam int          VB  [NV] = '{0, 0, 2, 3, 1, 1, 5, 19, 10, 8, 0};
  localparam bit          VS  [NV] = '{1, 1, 0, 1, 1, 1, 0, 0, 1, 1, 0};
  localparam longint      VM  [NV] = '{500000, 499999, 0, 453000, 403000, 402000,
                                       497001, 497000, 0, 100000, 500000};
  localparam int          VP  [NV] = '{0, 10, 5, 30, 0, 3, 0, 40, 0, 7, 20};
  localparam bit          VNF [NV] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 1};
  localparam logic [15:0] VA  [NV] = '{16'h0000, 16'h0001, 16'h0500, 16'h0150, 16'h0097,
                                       16'h0100, 16'h0000, 16'h0997, 16'h0500, 16'h0400,
                                       16'h0000};
  string vtag [NV] = '{"v0 equal R3", "v1 midband R2", "v2 pos R4", "v3 band R2",
                       "v4 slot47 R6", "v5 gap R5", "v6 nf R8", "v7 last R7",
                       "v8 zero R4", "v9 neg R4", "v10 full R8"};

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(done_o == 1'b0, "R1 done", done_o, 0);
    check(not_found_o == 1'b0, "R1 nf", not_found_o, 0);
    check(match_addr_o == 16'h0, "R1 addr", match_addr_o, 0);
    check(rd_band_o == 5'd0, "R1 band", rd_band_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int i = 0; i < NV; i++) begin
      start_pulse(VB[i], VS[i], VM[i], VP[i]);
      wait_check(VNF[i], VA[i], vtag[i]);
    end

    // R9: start during a running search is ignored
    start_pulse(0, 1'b0, 500000, 0);
    repeat (100) @(negedge clk_i);
    start_i = 1'b1; start_band_i = 5'd3; arg_i = enc(1'b1, 500000);
    @(negedge clk_i);
    start_i = 1'b0;
    check(rd_band_o != 5'd3, "R9 band kept", rd_band_o, 3);
    wait_check(1'b1, 16'h0000, "busy start R9");

    // R10: result held, then cleared by next start
    repeat (20) @(negedge clk_i);
    check(done_o && not_found_o, "R10 held", {done_o, not_found_o}, 3);
    start_pulse(0, 1'b1, 500000, 10);
    check(done_o == 1'b0, "R10 cleared", done_o, 0);
    check(not_found_o == 1'b0, "R10 nf cleared", not_found_o, 0);
    wait_check(1'b0, 16'h0000, "after clear R10");

    // R11: invalid word at band 0 slot 47 is skipped
    mask_en = 1'b1; mask_band = 0; mask_slot = 47;
    start_pulse(0, 1'b1, 453000, 0);
    wait_check(1'b0, 16'h0050, "invalid R11");
    mask_en = 1'b0;

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule